// File: doc/BRIEF.md
# Dual-Path Tuner Loop Divider

This block divides a local-oscillator signal down to the comparison rate of a tuner phase-locked loop. It runs in one system clock domain. Each local-oscillator cycle arrives as a one-clock qualifier strobe. There is one strobe input for the high-band oscillator and one for the low-band oscillator. Every time a full division completes, the block emits a single-cycle pulse for the phase comparator.

Two control bits pick the division path:
- **High-band path (band bit set):** the high-band strobes pass through a fixed divide-by-two stage, then through a dual-modulus (16/17) swallow counter. The overall ratio is twice the programmed divisor.
- **Swallow path (band bit clear, mode bit set):** the low-band strobes drive the swallow counter directly.
- **Direct path (both bits clear):** the low-band strobes feed a 12-bit modulo counter, and only the low 12 divisor bits matter.

A divisor below the floor of the active path is raised to that floor, and an error flag reports this. The divisor and the path are taken up only when the running period ends.

Top module: `lo_divider`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `div_pulse` and `range_err` are 0; reset loads the configuration on the inputs as the active one and restarts the count.
- R2: With `cfg_band`=1 (any `cfg_mode`), one output period spans exactly 2·N strobes of `hb_tick`; `lb_tick` has no effect on the period.
- R3: With `cfg_band`=0 and `cfg_mode`=1, one output period spans exactly N strobes of `lb_tick`; `hb_tick` has no effect.
- R4: With `cfg_band`=0 and `cfg_mode`=0, N is `cfg_div[11:0]` and one period spans N strobes of `lb_tick`; bits 15:12 are ignored and raise no error.
- R5: On the two swallow paths, a `cfg_div` below 272 is used as 272 and `range_err` is 1 one cycle later.
- R6: On the direct path, a `cfg_div[11:0]` below 4 is used as 4 and `range_err` is 1 one cycle later.
- R7: `range_err` is registered: it shows whether the configuration seen at the previous clock edge was legal.
- R8: The largest divisors work exactly: 65535 on the swallow path and 4095 on the direct path.
- R9: A configuration change made during a period takes effect only from the next period; the current period keeps its old length.
- R10: `div_pulse` is high for exactly one clock cycle, in the cycle after the strobe that completes a period.
- R11: In cycles without any strobe the count holds and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | One strobe per high-band oscillator cycle |
| lb_tick | input | 1 | One strobe per low-band oscillator cycle |
| cfg_div | input | 16 | Programmed divisor |
| cfg_band | input | 1 | 1: high-band path with divide-by-two stage |
| cfg_mode | input | 1 | With band 0: 1 swallow path, 0 direct path |
| div_pulse | output | 1 | Single-cycle pulse per completed division |
| range_err | output | 1 | Divisor was below the floor of the selected path |

## Verification
The pulse is registered, so it appears in the cycle right after the edge that consumes the completing strobe. The bench samples one time unit after each rising edge and counts the strobes applied up to that edge. The count at the first pulse is therefore the exact period. `range_err` is due one edge after a configuration is applied, and the bench reads it only after at least one edge has passed with that configuration. For the deferred-load case, the bench counts the strobes of the interrupted period and of the following period separately.

// File: rtl/lodiv_pkg.sv
`timescale 1ns/1ps
package lodiv_pkg;
  typedef enum logic [1:0] {
    PATH_PRE  = 2'd0,
    PATH_SWAL = 2'd1,
    PATH_DIR  = 2'd2
  } path_e;
endpackage

// File: rtl/lodiv_clamp.sv
`timescale 1ns/1ps
module lodiv_clamp
  import lodiv_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int DIRECT_W   = 12,
  parameter int SWAL_MIN   = 272,
  parameter int DIRECT_MIN = 4
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic             band_i,
  input  logic             mode_i,
  output path_e            path_o,
  output logic [DIV_W-1:0] n_o,
  output logic             oor_o
);
  logic [DIRECT_W-1:0] low_part;
  assign low_part = div_i[DIRECT_W-1:0];

  always_comb begin
    if (band_i)      path_o = PATH_PRE;
    else if (mode_i) path_o = PATH_SWAL;
    else             path_o = PATH_DIR;
  end

  always_comb begin
    n_o   = div_i;
    oor_o = 1'b0;
    if (path_o == PATH_DIR) begin
      n_o = {{(DIV_W-DIRECT_W){1'b0}}, low_part};
      if (low_part < DIRECT_W'(DIRECT_MIN)) begin
        n_o   = DIV_W'(DIRECT_MIN);
        oor_o = 1'b1;
      end
    end else if (div_i < DIV_W'(SWAL_MIN)) begin
      n_o   = DIV_W'(SWAL_MIN);
      oor_o = 1'b1;
    end
  end
endmodule

// File: rtl/lodiv_prescaler.sv
`timescale 1ns/1ps
module lodiv_prescaler #(
  parameter int LOG2 = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick_i,
  output logic tick_o
);
  logic [LOG2-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !en)  phase <= '0;
    else if (tick_i) phase <= phase + 1'b1;
  end

  assign tick_o = en && tick_i && (&phase);
endmodule

// File: rtl/lodiv_swallow.sv
`timescale 1ns/1ps
module lodiv_swallow #(
  parameter int DIV_W   = 16,
  parameter int SW_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] n_i,
  output logic             done_o
);
  localparam int MAIN_W = DIV_W - SW_LOG2;
  localparam int PC_W   = SW_LOG2 + 1;

  logic [SW_LOG2-1:0] swal_cnt;
  logic [MAIN_W-1:0]  main_cnt;
  logic [PC_W-1:0]    pc;
  logic [MAIN_W-1:0]  mcnt;
  logic               long_cycle;
  logic [PC_W-1:0]    pc_last;
  logic               pc_wrap;
  logic               m_wrap;

  assign swal_cnt   = n_i[SW_LOG2-1:0];
  assign main_cnt   = n_i[DIV_W-1:SW_LOG2];
  assign long_cycle = (mcnt < MAIN_W'(swal_cnt));
  assign pc_last    = long_cycle ? PC_W'(2**SW_LOG2) : PC_W'(2**SW_LOG2 - 1);
  assign pc_wrap    = (pc == pc_last);
  assign m_wrap     = (mcnt == main_cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pc   <= '0;
      mcnt <= '0;
    end else if (tick_i) begin
      if (pc_wrap) begin
        pc   <= '0;
        mcnt <= m_wrap ? '0 : mcnt + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  assign done_o = en && tick_i && pc_wrap && m_wrap;
endmodule

// File: rtl/lodiv_direct.sv
`timescale 1ns/1ps
module lodiv_direct #(
  parameter int DIRECT_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tick_i,
  input  logic [DIRECT_W-1:0] n_i,
  output logic                done_o
);
  logic [DIRECT_W-1:0] cnt;
  logic                at_end;

  assign at_end = (cnt == n_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick_i) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  assign done_o = en && tick_i && at_end;
endmodule

// File: rtl/lo_divider.sv
`timescale 1ns/1ps
module lo_divider
  import lodiv_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int DIRECT_W   = 12,
  parameter int SW_LOG2    = 4,
  parameter int PRE_LOG2   = 1,
  parameter int SWAL_MIN   = 272,
  parameter int DIRECT_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_tick,
  input  logic             lb_tick,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_band,
  input  logic             cfg_mode,
  output logic             div_pulse,
  output logic             range_err
);
  path_e            nxt_path;
  logic [DIV_W-1:0] nxt_n;
  logic             nxt_oor;
  path_e            act_path;
  logic [DIV_W-1:0] act_n;
  logic             pre_tick;
  logic             sw_en;
  logic             sw_tick;
  logic             sw_done;
  logic             dir_done;
  logic             period_end;

  lodiv_clamp #(
    .DIV_W(DIV_W), .DIRECT_W(DIRECT_W),
    .SWAL_MIN(SWAL_MIN), .DIRECT_MIN(DIRECT_MIN)
  ) u_clamp (
    .div_i(cfg_div), .band_i(cfg_band), .mode_i(cfg_mode),
    .path_o(nxt_path), .n_o(nxt_n), .oor_o(nxt_oor)
  );

  lodiv_prescaler #(.LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .en(act_path == PATH_PRE),
    .tick_i(hb_tick), .tick_o(pre_tick)
  );

  assign sw_en   = (act_path != PATH_DIR);
  assign sw_tick = (act_path == PATH_PRE) ? pre_tick : lb_tick;

  lodiv_swallow #(.DIV_W(DIV_W), .SW_LOG2(SW_LOG2)) u_swal (
    .clk(clk), .rst(rst), .en(sw_en), .tick_i(sw_tick),
    .n_i(act_n), .done_o(sw_done)
  );

  lodiv_direct #(.DIRECT_W(DIRECT_W)) u_dir (
    .clk(clk), .rst(rst), .en(act_path == PATH_DIR), .tick_i(lb_tick),
    .n_i(act_n[DIRECT_W-1:0]), .done_o(dir_done)
  );

  assign period_end = sw_en ? sw_done : dir_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_path  <= nxt_path;
      act_n     <= nxt_n;
      div_pulse <= 1'b0;
      range_err <= 1'b0;
    end else begin
      div_pulse <= period_end;
      range_err <= nxt_oor;
      if (period_end) begin
        act_path <= nxt_path;
        act_n    <= nxt_n;
      end
    end
  end
endmodule

// File: rtl/lo_divider_chk.sv
`timescale 1ns/1ps
module lo_divider_chk #(
  parameter int DIV_W      = 16,
  parameter int DIRECT_W   = 12,
  parameter int SWAL_MIN   = 272,
  parameter int DIRECT_MIN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hb_tick,
  input logic             lb_tick,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_band,
  input logic             cfg_mode,
  input logic             div_pulse,
  input logic             range_err
);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!hb_tick && !lb_tick) |=> !div_pulse);

  // R5
  swal_floor_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_band || cfg_mode) && cfg_div < DIV_W'(SWAL_MIN)) |=> range_err);

  // R6
  dir_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_band && !cfg_mode && cfg_div[DIRECT_W-1:0] < DIRECT_W'(DIRECT_MIN)) |=> range_err);

  // R4
  dir_upper_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_band && !cfg_mode && cfg_div[DIRECT_W-1:0] >= DIRECT_W'(DIRECT_MIN)) |=> !range_err);
endmodule

bind lo_divider lo_divider_chk #(
  .DIV_W(DIV_W), .DIRECT_W(DIRECT_W),
  .SWAL_MIN(SWAL_MIN), .DIRECT_MIN(DIRECT_MIN)
) u_chk (
  .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick),
  .cfg_div(cfg_div), .cfg_band(cfg_band), .cfg_mode(cfg_mode),
  .div_pulse(div_pulse), .range_err(range_err)
);

// File: tb/sim_lo_divider.sv
`timescale 1ns/1ps
module sim_lo_divider;
  logic        clk = 1'b0;
  logic        rst;
  logic        hb_tick, lb_tick;
  logic [15:0] cfg_div;
  logic        cfg_band, cfg_mode;
  logic        div_pulse, range_err;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  lo_divider u0 (
    .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick),
    .cfg_div(cfg_div), .cfg_band(cfg_band), .cfg_mode(cfg_mode),
    .div_pulse(div_pulse), .range_err(range_err)
  );

  // {band, mode, div[15:0], expected period in strobes[17:0], expected err}
  localparam int NV = 13;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd272,   18'd544,   1'b0},  // R2
    {1'b1, 1'b0, 16'd1000,  18'd2000,  1'b0},  // R2
    {1'b1, 1'b1, 16'd300,   18'd600,   1'b0},  // R2 mode ignored
    {1'b1, 1'b0, 16'd100,   18'd544,   1'b1},  // R5
    {1'b0, 1'b1, 16'd272,   18'd272,   1'b0},  // R3
    {1'b0, 1'b1, 16'd1234,  18'd1234,  1'b0},  // R3
    {1'b0, 1'b1, 16'd65535, 18'd65535, 1'b0},  // R8
    {1'b0, 1'b1, 16'd5,     18'd272,   1'b1},  // R5
    {1'b0, 1'b0, 16'd4,     18'd4,     1'b0},  // R4
    {1'b0, 1'b0, 16'd4095,  18'd4095,  1'b0},  // R8
    {1'b0, 1'b0, 16'hF00A,  18'd10,    1'b0},  // R4 upper bits
    {1'b0, 1'b0, 16'd2,     18'd4,     1'b1},  // R6
    {1'b0, 1'b0, 16'h1003,  18'd4,     1'b1}   // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    check(!div_pulse && !range_err, "R1 in reset", {div_pulse, range_err}, 0);
    rst = 1'b0;
  endtask

  // counts strobes consumed until a pulse is seen
  task automatic measure(output int cnt);
    cnt = 0;
    forever begin
      step();
      cnt++;
      if (div_pulse || cnt > 140000) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    rst = 1'b1; hb_tick = 1'b1; lb_tick = 1'b1;
    cfg_div = 16'd100; cfg_band = 1'b0; cfg_mode = 1'b1;
    do_reset();
    // R1: first cycle after reset
    step();
    check(!div_pulse, "R1 after reset", div_pulse, 0);

    // table walk: both strobes run every cycle
    for (int i = 0; i < NV; i++) begin
      int np;
      cfg_band = VEC[i][36];
      cfg_mode = VEC[i][35];
      cfg_div  = VEC[i][34:19];
      hb_tick  = 1'b1;
      lb_tick  = 1'b1;
      do_reset();
      np = (VEC[i][18:1] < 3000) ? 3 : 1;
      for (int k = 0; k < np; k++) begin
        measure(p);
        check(p == int'(VEC[i][18:1]), "R2/R3/R4/R5/R6/R8 period", p, int'(VEC[i][18:1]));
        step();
        check(!div_pulse, "R10 pulse width", div_pulse, 0);
        p = 0;
        // the extra step consumed one strobe of the next period
        if (k + 1 < np) begin
          int q;
          measure(q);
          check(q + 1 == int'(VEC[i][18:1]), "R10 next period", q + 1, int'(VEC[i][18:1]));
          k++;
        end
      end
      check(range_err == VEC[i][0], "R5/R6/R7 range_err", range_err, VEC[i][0]);
    end

    // R9: change direct divisor mid-period
    cfg_band = 1'b0; cfg_mode = 1'b0; cfg_div = 16'd100;
    do_reset();
    p = 0;
    for (int k = 0; k < 30; k++) begin step(); p++; end
    cfg_div = 16'd10;
    begin
      int q;
      measure(q);
      check(p + q == 100, "R9 old period kept", p + q, 100);
      measure(q);
      check(q == 10, "R9 new period", q, 10);
    end

    // R11: no strobes, count holds
    cfg_div = 16'd4;
    do_reset();
    step();
    hb_tick = 1'b0; lb_tick = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 50; k++) begin step(); if (div_pulse) seen = 1'b1; end
      check(!seen, "R11 idle no pulse", seen, 0);
      lb_tick = 1'b1;
      measure(p);
      check(p == 3, "R11 count held", p, 3);
    end

    // R7: flag follows config one edge later
    cfg_div = 16'd1;
    step();
    check(range_err == 1'b1, "R7 err rise", range_err, 1);
    cfg_div = 16'd9;
    step();
    check(range_err == 1'b0, "R7 err fall", range_err, 0);

    // R3: hb strobes alone do nothing on swallow path
    cfg_band = 1'b0; cfg_mode = 1'b1; cfg_div = 16'd272;
    do_reset();
    hb_tick = 1'b1; lb_tick = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 600; k++) begin step(); if (div_pulse) seen = 1'b1; end
      check(!seen, "R3 hb ignored", seen, 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule